// File: doc/BRIEF.md
# Clocked Serial Keyboard Link Transceiver

This block receives keyboard-style serial frames on a clock line and a data line that are both driven by the remote side. The same frames carry a byte in the opposite direction on a separate output line. The remote side supplies every clock pulse. On each falling edge of that clock the block steps through a start bit, eight data bits, a parity bit and a stop bit. A host keyboard and a host computer can share the same two lines.

Each received byte is stored with its first bit in bit 7 and is pushed into a receive queue. While a frame is being clocked in, the block shifts the byte at the head of a transmit queue out on the output line, most significant bit first. When the transmit queue is empty, it sends an all-ones byte, which the far side treats as filler. The local logic pops received bytes and pushes bytes to send through plain single-cycle strobes.

Top module: `kbl_link_top`

## Requirements
- R1: In the wait state, a falling edge of the line clock with the line data low starts a frame. A falling edge with data high leaves the block waiting and starts nothing.
- R2: The eight data bits that follow the start bit are shifted in so that the first one sent lands in bit 7 of the received byte.
- R3: On the parity falling edge the received byte is pushed into the receive queue. The value of the parity bit has no effect on the stored byte.
- R4: After the parity edge, exactly one further falling edge (the stop bit) is consumed, and the block then waits for a new start bit. Frames can follow each other directly.
- R5: On the start edge, the head of the transmit queue is loaded. The byte is driven on `ser_o` most significant bit first, with each bit appearing after one data falling edge and held until the next falling edge.
- R6: When the transmit queue is empty at the start edge, the byte 0xFF is sent instead. A byte pushed later goes out in a following frame.
- R7: The transmit queue is popped at the parity edge, and only when a real byte was loaded at the start edge.
- R8: `ser_o` is high after reset, and from the parity edge until the first data edge of the next frame.
- R9: Each queue keeps up to 255 bytes in arrival order. Receive writes make no full check.
- R10: `rx_avail_o` is low when the receive queue is empty. `rx_pop_i` removes the byte shown on `rx_data_o`.
- R11: The line clock and line data pass through two-stage synchronisers. A falling edge is counted once, when the synchronised clock goes from 1 to 0, however long the clock then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk_i | input | 1 | Remote-driven line clock, asynchronous |
| line_dat_i | input | 1 | Remote-driven line data, asynchronous |
| ser_o | output | 1 | Serial output bit, registered |
| tx_push_i | input | 1 | Push `tx_data_i` into the transmit queue |
| tx_data_i | input | 8 | Byte to transmit |
| rx_pop_i | input | 1 | Remove the head of the receive queue |
| rx_data_o | output | 8 | Head of the receive queue |
| rx_avail_o | output | 1 | Receive queue is not empty |

## Verification
The hardest state to reach from the ports is a queue holding its full 255 entries. Getting there takes 255 complete frames on the line with no pops in between. The bench clocks in that many frames, each carrying a distinct value, and then drains the queue to confirm order and count. A second case that needs care is the start edge with data high, which must leave the block waiting. The bench applies such an edge just before a real frame, so any slip in framing shows up as a misaligned received byte.

// File: rtl/kbl_pkg.sv
package kbl_pkg;
  typedef enum logic [1:0] {
    ST_WAIT,
    ST_BITS,
    ST_PAR,
    ST_STOP
  } kbl_state_e;
endpackage

// File: rtl/kbl_sync.sv
module kbl_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/kbl_fifo.sv
module kbl_fifo #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push)           wr_ptr <= wr_ptr + 1'b1;
      if (pop && !empty)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign empty = (wr_ptr == rd_ptr);
  assign dout  = mem[rd_ptr];
endmodule

// File: rtl/kbl_link_top.sv
module kbl_link_top #(
  parameter int FRAME_BITS  = 8,
  parameter int FIFO_AW     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  line_clk_i,
  input  logic                  line_dat_i,
  output logic                  ser_o,
  input  logic                  tx_push_i,
  input  logic [FRAME_BITS-1:0] tx_data_i,
  input  logic                  rx_pop_i,
  output logic [FRAME_BITS-1:0] rx_data_o,
  output logic                  rx_avail_o
);
  import kbl_pkg::*;

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic clk_s, dat_s, clk_d, fall;
  kbl_state_e state;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME_BITS-1:0] rx_sh, tx_sh, tx_head;
  logic tx_real, ser_q, rx_push, tx_pop, tx_empty, rx_empty;

  kbl_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_clk (
    .clk(clk), .rst(rst), .d(line_clk_i), .q(clk_s));
  kbl_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_dat (
    .clk(clk), .rst(rst), .d(line_dat_i), .q(dat_s));

  assign fall    = clk_d & ~clk_s;
  assign rx_push = fall && (state == ST_PAR);
  assign tx_pop  = rx_push && tx_real;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d   <= 1'b1;
      state   <= ST_WAIT;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '1;
      tx_real <= 1'b0;
      ser_q   <= 1'b1;
    end else begin
      clk_d <= clk_s;
      if (fall) begin
        unique case (state)
          ST_WAIT: if (!dat_s) begin
            state   <= ST_BITS;
            bit_cnt <= '0;
            tx_sh   <= tx_empty ? '1 : tx_head;
            tx_real <= !tx_empty;
          end
          ST_BITS: begin
            rx_sh   <= {rx_sh[FRAME_BITS-2:0], dat_s};
            tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b1};
            ser_q   <= tx_sh[FRAME_BITS-1];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) state <= ST_PAR;
          end
          ST_PAR: begin
            ser_q <= 1'b1;
            state <= ST_STOP;
          end
          ST_STOP: state <= ST_WAIT;
          default: state <= ST_WAIT;
        endcase
      end
    end
  end

  kbl_fifo #(.DW(FRAME_BITS), .AW(FIFO_AW)) u_rx_q (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_sh),
    .pop(rx_pop_i), .dout(rx_data_o), .empty(rx_empty));

  kbl_fifo #(.DW(FRAME_BITS), .AW(FIFO_AW)) u_tx_q (
    .clk(clk), .rst(rst), .push(tx_push_i), .din(tx_data_i),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty));

  assign ser_o      = ser_q;
  assign rx_avail_o = !rx_empty;
endmodule

// File: rtl/kbl_link_chk.sv
module kbl_link_chk #(
  parameter int FRAME_BITS = 8
) (
  input logic clk,
  input logic rst,
  input kbl_pkg::kbl_state_e state,
  input logic fall,
  input logic dat_s,
  input logic [$clog2(FRAME_BITS)-1:0] bit_cnt,
  input logic ser_o,
  input logic rx_push,
  input logic tx_pop
);
  import kbl_pkg::*;
  localparam int CW = $clog2(FRAME_BITS);

  AST_START_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS && $past(state) == ST_WAIT) |-> !$past(dat_s)); // R1
  AST_LAST_BIT_TO_PAR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS && fall && bit_cnt == CW'(FRAME_BITS - 1)) |=> state == ST_PAR); // R2
  AST_PUSH_THEN_STOP: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> state == ST_STOP); // R3
  AST_STOP_TO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP && fall) |=> state == ST_WAIT); // R4
  AST_POP_WITH_PUSH: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> rx_push); // R7
  AST_SER_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT || state == ST_STOP) |-> ser_o); // R8
  AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(state)); // R11
endmodule

bind kbl_link_top kbl_link_chk #(.FRAME_BITS(FRAME_BITS)) chk_i (
  .clk(clk), .rst(rst), .state(state), .fall(fall), .dat_s(dat_s),
  .bit_cnt(bit_cnt), .ser_o(ser_o), .rx_push(rx_push), .tx_pop(tx_pop));

// File: tb/kbl_link_top_tb_top.sv
module kbl_link_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_clk = 1'b1, line_dat = 1'b1;
  logic tx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic ser_o, rx_avail;
  logic [7:0] rx_data;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  kbl_link_top dut_i (
    .clk(clk), .rst(rst), .line_clk_i(line_clk), .line_dat_i(line_dat),
    .ser_o(ser_o), .tx_push_i(tx_push), .tx_data_i(tx_data),
    .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_avail_o(rx_avail));

  // {load tx, rx byte on line, tx byte}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'hA5, 8'h3C},
    {1'b0, 8'h01, 8'h00},
    {1'b1, 8'h80, 8'hC3},
    {1'b1, 8'hFF, 8'h00},
    {1'b0, 8'h00, 8'h77},
    {1'b1, 8'h5A, 8'h81}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic line_edge(input logic b, input int low_len, output logic sb);
    line_dat = b;
    tick(3);
    line_clk = 1'b0;
    tick(low_len);
    sb = ser_o;
    line_clk = 1'b1;
    tick(4);
  endtask

  task automatic frame(input logic [7:0] v, input logic par, input int start_low,
                       output logic [7:0] cap, output logic par_ser);
    logic s;
    line_edge(1'b0, start_low, s);
    cap = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      line_edge(v[i], 5, s);
      cap = {cap[6:0], s};
    end
    line_edge(par, 5, par_ser);
    line_edge(1'b1, 5, s);
  endtask

  task automatic push_tx(input logic [7:0] v);
    tx_push = 1'b1; tx_data = v;
    tick(1);
    tx_push = 1'b0;
  endtask

  task automatic pop_rx(input string req, input logic [7:0] exp);
    chk(req, {7'd0, rx_avail}, 8'd1);
    chk(req, rx_data, exp);
    rx_pop = 1'b1;
    tick(1);
    rx_pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] cap;
    logic ps, s;
    tick(4);
    rst = 1'b0;
    tick(2);
    chk("R8 reset ser", {7'd0, ser_o}, 8'd1);
    chk("R10 reset empty", {7'd0, rx_avail}, 8'd0);

    // Table walk: R2 R3 R5 R6 R10
    for (int i = 0; i < 6; i++) begin
      if (VEC[i][16]) push_tx(VEC[i][7:0]);
      frame(VEC[i][15:8], i[0], 5, cap, ps);
      chk("R5/R6 tx byte", cap, VEC[i][16] ? VEC[i][7:0] : 8'hFF);
      chk("R8 ser after parity", {7'd0, ps}, 8'd1);
      pop_rx("R2/R3 rx byte", VEC[i][15:8]);
      chk("R10 empty after pop", {7'd0, rx_avail}, 8'd0);
    end

    // R1: edge with data high is ignored
    line_edge(1'b1, 5, s);
    chk("R1 no frame on high", {7'd0, rx_avail}, 8'd0);
    frame(8'h3C, 1'b0, 5, cap, ps);
    pop_rx("R1 aligned after high edge", 8'h3C);

    // R3 parity value ignored
    frame(8'h96, 1'b1, 5, cap, ps);
    pop_rx("R3 parity 1", 8'h96);
    frame(8'h96, 1'b0, 5, cap, ps);
    pop_rx("R3 parity 0", 8'h96);

    // R7 R6 R4: queue order and no pop on filler, back to back frames
    push_tx(8'h12);
    push_tx(8'h34);
    frame(8'h00, 1'b0, 5, cap, ps);
    chk("R7 first", cap, 8'h12);
    frame(8'h00, 1'b0, 5, cap, ps);
    chk("R4 R7 second", cap, 8'h34);
    frame(8'h00, 1'b0, 5, cap, ps);
    chk("R6 filler", cap, 8'hFF);
    push_tx(8'h5E);
    frame(8'h00, 1'b0, 5, cap, ps);
    chk("R7 kept after filler", cap, 8'h5E);
    for (int i = 0; i < 4; i++) begin
      rx_pop = 1'b1; tick(1); rx_pop = 1'b0;
    end

    // R11 long low start bit counts once
    frame(8'hC7, 1'b0, 40, cap, ps);
    pop_rx("R11 long low edge", 8'hC7);

    // R9 fill 255 entries then drain
    for (int i = 0; i < 255; i++) frame(8'(i), 1'b0, 5, cap, ps);
    for (int i = 0; i < 255; i++) pop_rx("R9 order", 8'(i));
    chk("R9 drained", {7'd0, rx_avail}, 8'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule